// File: doc/BRIEF.md
# Cartridge Bank Controller with Real-Time Clock Registers

This block sits between a CPU bus and the external ROM and RAM arrays of a cartridge. It decodes write strobes in the low 32 KiB of the address space into control actions: choosing a 7-bit ROM bank for the switchable ROM area, choosing either a RAM bank or one of five clock registers for the external RAM window, arming a RAM-enable flag, and freezing a snapshot of the clock. It forms the physical ROM and RAM addresses and multiplexes the read data back onto the bus.

The clock is a register file of seconds, minutes, hours and a 9-bit day count with halt and carry flags. It is advanced by a one-second tick input. When the selector points at a clock register, the RAM window reads and writes that register instead of RAM. A latch control copies the live registers into a held copy, and reads then return the held copy until the latch is released. Bus accesses finish in the cycle they are presented. Reads are combinational from the address and from registered state, and writes take effect at the next clock edge. There is no back-pressure on any pin.

Top module: `bank_rtc_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the selector is 0, the latched flag is clear, RAM is disabled (`ram_en` low), and all five clock registers read as zero.
- R2: A write to 0x0000–0x1FFF sets `ram_en` high when the data byte is exactly 0x0A and low for any other byte.
- R3: A write to 0x2000–0x3FFF loads the ROM bank from data bits 6:0, and bit 7 is ignored. A value of zero is replaced by 1. Reads in 0x4000–0x7FFF drive `rom_addr` = bank × 0x4000 + (addr − 0x4000). Reads in 0x0000–0x3FFF drive `rom_addr` = addr.
- R4: A banked ROM read with a bank ≥ NUM_ROM_BANKS returns 0x00. Reads at 0x8000–0x9FFF and at 0xC000 and above return 0x00.
- R5: A write to 0x4000–0x5FFF with a data value of 0x08–0x0C stores that value as the selector. Any other data value stores data bits 1:0. With a RAM bank selected, window accesses at 0xA000–0xBFFF use `ram_addr` = bank × 0x2000 + (addr − 0xA000).
- R6: When the selected RAM bank is ≥ NUM_RAM_BANKS, a window read returns 0x00 and a window write keeps `ram_we` low. A valid RAM bank write asserts `ram_we` with `ram_wdata` equal to the data byte.
- R7: Selector values 0x08 to 0x0C select clock registers 0 to 4. Register 0 is seconds, 1 is minutes, 2 is hours, 3 is the day count low byte, and 4 is the day high byte. In the day high byte, bit 0 is day bit 8, bit 6 is halt and bit 7 is carry, and the other bits read as zero. With the latch released, a window read returns the live register.
- R8: A window write while a clock register is selected stores the byte into that live register and keeps `ram_we` low.
- R9: A write to 0x6000–0x7FFF with data bit 0 set copies the live registers into the held copy and sets the latched flag. Window reads of clock registers then return the held copy. A write with bit 0 clear releases the latch, and reads return the live value again.
- R10: A tick advances the seconds. Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours. Hours roll from 23 to 0 and carry into the day count. The day count rolls from 511 to 0 and sets the carry bit.
- R11: While the halt bit is set, ticks change no clock register.
- R12: A clock-register write in the same cycle as a tick wins: the written value is stored and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | 16 | CPU address |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data |
| ram_en | output | 1 | RAM-enable flag |
| rom_addr | output | 21 | External ROM address |
| rom_rdata | input | 8 | External ROM data |
| ram_addr | output | 15 | External RAM address |
| ram_we | output | 1 | External RAM write enable |
| ram_wdata | output | 8 | External RAM write data |
| ram_rdata | input | 8 | External RAM data |

## Verification
Every 8-bit value is written to the enable range, which separates the single key value from all its neighbours. Every ROM bank value from 0 to 127 is written with bit 7 toggled, which exposes the zero-to-one substitution, the masking of bit 7 and the boundary between in-range and out-of-range banks. All sixteen selector values are swept with a write and a read-back in the window, which separates the RAM banks, the out-of-range bank, the values that alias onto a bank and the five clock registers. Tick sequences starting just below every rollover point, followed by the latch and halt cases and a write that collides with a tick, cover the clock.

// File: rtl/bank_rtc_pkg.sv
package bank_rtc_pkg;
  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] dlo;
    logic [7:0] dhi;
  } rtc_t;

  localparam logic [7:0] ENABLE_KEY   = 8'h0A;
  localparam logic [3:0] CLK_SEL_LO   = 4'h8;
  localparam logic [3:0] CLK_SEL_HI   = 4'hC;
  localparam logic [7:0] DHI_MASK     = 8'hC1;
  localparam int         HALT_BIT     = 6;
  localparam int         CARRY_BIT    = 7;
  localparam int         SEL_W        = 4;

  // Region codes taken from address bits 15:13.
  localparam logic [2:0] RG_KEY   = 3'd0;
  localparam logic [2:0] RG_ROMB  = 3'd1;
  localparam logic [2:0] RG_SEL   = 3'd2;
  localparam logic [2:0] RG_LATCH = 3'd3;
  localparam logic [2:0] RG_WIN   = 3'd5;
endpackage

// File: rtl/bank_select_regs.sv
module bank_select_regs
  import bank_rtc_pkg::*;
#(
  parameter int ROM_BW    = 7,
  parameter bit HAS_CLOCK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_key,
  input  logic              wr_romb,
  input  logic              wr_sel,
  input  logic              wr_latch,
  input  logic [7:0]        wdata,
  output logic              ram_en,
  output logic [ROM_BW-1:0] rom_bank,
  output logic [SEL_W-1:0]  sel,
  output logic              latched
);
  logic [SEL_W-1:0]  sel_next;
  logic [ROM_BW-1:0] bank_next;

  always_comb begin
    if (HAS_CLOCK && wdata >= {4'h0, CLK_SEL_LO} && wdata <= {4'h0, CLK_SEL_HI})
      sel_next = wdata[SEL_W-1:0];
    else
      sel_next = {{(SEL_W-2){1'b0}}, wdata[1:0]};
    bank_next = wdata[ROM_BW-1:0];
    if (bank_next == '0) bank_next = {{(ROM_BW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_en   <= 1'b0;
      rom_bank <= {{(ROM_BW-1){1'b0}}, 1'b1};
      sel      <= '0;
      latched  <= 1'b0;
    end else begin
      if (wr_key)   ram_en   <= (wdata == ENABLE_KEY);
      if (wr_romb)  rom_bank <= bank_next;
      if (wr_sel)   sel      <= sel_next;
      if (wr_latch) latched  <= wdata[0];
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import bank_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr,
  input  logic [2:0] idx,
  input  logic [7:0] wdata,
  input  logic       snap,
  output rtc_t       live,
  output rtc_t       held
);
  rtc_t       nxt;
  logic [9:0] day_sum;

  always_comb begin
    nxt     = live;
    day_sum = {1'b0, live.dhi[0], live.dlo} + 10'd1;
    if (!live.dhi[HALT_BIT]) begin
      if (live.sec >= 8'd59) begin
        nxt.sec = 8'd0;
        if (live.min >= 8'd59) begin
          nxt.min = 8'd0;
          if (live.hr >= 8'd23) begin
            nxt.hr     = 8'd0;
            nxt.dlo    = day_sum[7:0];
            nxt.dhi[0] = day_sum[8];
            if (day_sum[9]) nxt.dhi[CARRY_BIT] = 1'b1;
          end else begin
            nxt.hr = live.hr + 8'd1;
          end
        end else begin
          nxt.min = live.min + 8'd1;
        end
      end else begin
        nxt.sec = live.sec + 8'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      held <= '0;
    end else begin
      if (wr) begin
        case (idx)
          3'd0:    live.sec <= wdata;
          3'd1:    live.min <= wdata;
          3'd2:    live.hr  <= wdata;
          3'd3:    live.dlo <= wdata;
          3'd4:    live.dhi <= wdata & DHI_MASK;
          default: ;
        endcase
      end else if (tick) begin
        live <= nxt;
      end
      if (snap) held <= live;
    end
  end
endmodule

// File: rtl/bank_rtc_ctrl.sv
module bank_rtc_ctrl
  import bank_rtc_pkg::*;
#(
  parameter int NUM_ROM_BANKS = 128,
  parameter int NUM_RAM_BANKS = 4,
  parameter bit HAS_RAM       = 1'b1,
  parameter bit HAS_CLOCK     = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1s,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        ram_en,
  output logic [20:0] rom_addr,
  input  logic [7:0]  rom_rdata,
  output logic [14:0] ram_addr,
  output logic        ram_we,
  output logic [7:0]  ram_wdata,
  input  logic [7:0]  ram_rdata
);
  localparam int ROM_BW    = 7;
  localparam int ROM_OFF_W = 14;
  localparam int RAM_OFF_W = 13;

  logic [2:0]        region;
  logic              in_win, clk_hit, ram_ok, rom_ok, snap;
  logic [ROM_BW-1:0] rom_bank;
  logic [SEL_W-1:0]  sel;
  logic              latched;
  rtc_t              live, held, src;
  logic [7:0]        clk_val;

  assign region = bus_addr[15:13];
  assign in_win = (region == RG_WIN);

  bank_select_regs #(.ROM_BW(ROM_BW), .HAS_CLOCK(HAS_CLOCK)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_key   (bus_wr && region == RG_KEY),
    .wr_romb  (bus_wr && region == RG_ROMB),
    .wr_sel   (bus_wr && region == RG_SEL),
    .wr_latch (bus_wr && region == RG_LATCH),
    .wdata    (bus_wdata),
    .ram_en   (ram_en),
    .rom_bank (rom_bank),
    .sel      (sel),
    .latched  (latched)
  );

  assign clk_hit = HAS_CLOCK && sel >= CLK_SEL_LO && sel <= CLK_SEL_HI;
  assign ram_ok  = HAS_RAM && !clk_hit && (32'(sel) < NUM_RAM_BANKS);
  assign rom_ok  = (32'(rom_bank) < NUM_ROM_BANKS);
  assign snap    = bus_wr && region == RG_LATCH && bus_wdata[0];

  generate
    if (HAS_CLOCK) begin : g_rtc
      rtc_regfile u_rtc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1s),
        .wr    (bus_wr && in_win && clk_hit),
        .idx   (sel[2:0]),
        .wdata (bus_wdata),
        .snap  (snap),
        .live  (live),
        .held  (held)
      );
    end else begin : g_no_rtc
      assign live = '0;
      assign held = '0;
    end
  endgenerate

  always_comb begin
    src = latched ? held : live;
    case (sel[2:0])
      3'd0:    clk_val = src.sec;
      3'd1:    clk_val = src.min;
      3'd2:    clk_val = src.hr;
      3'd3:    clk_val = src.dlo;
      3'd4:    clk_val = src.dhi;
      default: clk_val = 8'h00;
    endcase
  end

  assign rom_addr  = bus_addr[15:14] == 2'b00
                   ? {{ROM_BW{1'b0}}, bus_addr[ROM_OFF_W-1:0]}
                   : {rom_bank, bus_addr[ROM_OFF_W-1:0]};
  assign ram_addr  = {sel[1:0], bus_addr[RAM_OFF_W-1:0]};
  assign ram_wdata = bus_wdata;
  assign ram_we    = bus_wr && in_win && ram_ok;

  always_comb begin
    if (bus_addr[15:14] == 2'b00)      bus_rdata = rom_rdata;
    else if (bus_addr[15:14] == 2'b01) bus_rdata = rom_ok ? rom_rdata : 8'h00;
    else if (in_win)                   bus_rdata = clk_hit ? clk_val
                                                 : (ram_ok ? ram_rdata : 8'h00);
    else                               bus_rdata = 8'h00;
  end
endmodule

// File: rtl/bank_rtc_ctrl_sva.sv
module bank_rtc_ctrl_sva
  import bank_rtc_pkg::*;
#(
  parameter int NUM_RAM_BANKS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_1s,
  input logic [15:0] bus_addr,
  input logic        bus_wr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        ram_we,
  input logic [6:0]  rom_bank,
  input logic [3:0]  sel,
  input logic        latched,
  input rtc_t        live
);
  logic win, clk_sel, clk_wr;
  assign win     = bus_addr[15:13] == RG_WIN;
  assign clk_sel = sel >= CLK_SEL_LO && sel <= CLK_SEL_HI;
  assign clk_wr  = bus_wr && win && clk_sel;

  p_rom_bank_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rom_bank != 7'd0);

  p_oob_ram_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win && sel < 4'd4 && 32'(sel) >= NUM_RAM_BANKS) |-> (bus_rdata == 8'h00 && !ram_we));

  p_latch_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == RG_LATCH) |=> (latched == $past(bus_wdata[0])));

  p_sec_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && !live.dhi[HALT_BIT] && live.sec == 8'd59 && !clk_wr) |=> (live.sec == 8'd0));

  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (live.dhi[HALT_BIT] && !clk_wr) |=> $stable(live));

  p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_wr && sel == CLK_SEL_LO) |=> (live.sec == $past(bus_wdata)));
endmodule

bind bank_rtc_ctrl bank_rtc_ctrl_sva #(.NUM_RAM_BANKS(NUM_RAM_BANKS)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_1s   (tick_1s),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ram_we    (ram_we),
  .rom_bank  (rom_bank),
  .sel       (sel),
  .latched   (latched),
  .live      (live)
);

// File: tb/bank_rtc_ctrl_test.sv
module bank_rtc_ctrl_test;
  localparam int NROM = 100;
  localparam int NRAM = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1s = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h0;
  logic [7:0]  bus_rdata;
  logic        ram_en;
  logic [20:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic [14:0] ram_addr;
  logic        ram_we;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = 8'h0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic        seen_we;
  logic [14:0] seen_ram_addr;
  logic [7:0]  ram_m [int];

  bank_rtc_ctrl #(.NUM_ROM_BANKS(NROM), .NUM_RAM_BANKS(NRAM)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ram_en(ram_en),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  always #2 clk = ~clk;

  // ROM content is a pure function of the address.
  always_comb rom_rdata = rom_addr[7:0] ^ {1'b0, rom_addr[20:14]};

  always @(posedge clk) if (ram_we) ram_m[int'(ram_addr)] = ram_wdata;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit with_tick = 0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_1s = with_tick;
    #1;
    seen_we = ram_we; seen_ram_addr = ram_addr;
    @(negedge clk);
    bus_wr = 1'b0; tick_1s = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    ram_rdata = ram_m.exists(int'(ram_addr)) ? ram_m[int'(ram_addr)] : 8'h00;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); tick_1s = 1'b1;
    @(negedge clk); tick_1s = 1'b0;
  endtask

  task automatic rd_clk(input int idx, output logic [7:0] d);
    wr(16'h4000, 8'(8 + idx));
    rd(16'hA000, d);
  endtask

  task automatic set_clk(input int idx, input logic [7:0] v);
    wr(16'h4000, 8'(8 + idx));
    wr(16'hA000, v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 ram_en", int'(ram_en), 0);
    rd(16'h4000, d);
    chk("R1 rom bank 1", int'(rom_addr), 'h4000);
    rd(16'hA010, d);
    chk("R1 selector 0", int'(ram_addr), 'h0010);
    wr(16'h4000, 8'h08);
    rd(16'hA000, d);
    chk("R1 latch clear, clock zero", int'(d), 0);
    for (int i = 0; i < 5; i++) begin
      rd_clk(i, d);
      chk("R1 clock reg zero", int'(d), 0);
    end

    // R2: enable key, all byte values
    for (int v = 0; v < 256; v++) begin
      wr(16'h0000 + 16'(v * 31), 8'(v));
      chk("R2 ram_en", int'(ram_en), v == 'h0A ? 1 : 0);
    end

    // R3/R4: every ROM bank value, bit 7 toggled
    for (int b = 0; b < 128; b++) begin
      int eb, off, ea;
      eb = (b == 0) ? 1 : b;
      off = (b * 37) & 'h3FFF;
      ea = eb * 'h4000 + off;
      wr(16'h2000 + 16'(b), 8'(b) | ((b & 1) != 0 ? 8'h80 : 8'h00));
      rd(16'h4000 + 16'(off), d);
      chk("R3 rom_addr", int'(rom_addr), ea);
      chk("R4 banked rom data", int'(d), eb < NROM ? ((ea & 'hFF) ^ eb) : 0);
    end
    rd(16'h1234, d);
    chk("R3 fixed area addr", int'(rom_addr), 'h1234);
    chk("R3 fixed area data", int'(d), 'h34);
    rd(16'h8800, d);
    chk("R4 undecoded 8800", int'(d), 0);
    rd(16'hC000, d);
    chk("R4 undecoded C000", int'(d), 0);

    // R5/R6/R7/R8: every selector value
    for (int s = 0; s < 16; s++) begin
      logic [15:0] a;
      logic [7:0]  v;
      a = 16'hA000 + 16'(s * 5);
      v = 8'(s) ^ 8'h3C;
      wr(16'h4000, 8'(s));
      if (s >= 8 && s <= 12) begin
        wr(a, 8'(s));
        chk("R8 clock write no ram_we", int'(seen_we), 0);
        rd(a, d);
        chk("R7 clock reg readback", int'(d), s == 12 ? 0 : s);
      end else begin
        wr(a, v);
        chk("R5 ram_addr", int'(seen_ram_addr), (s & 3) * 'h2000 + s * 5);
        if ((s & 3) < NRAM) begin
          chk("R6 ram_we valid bank", int'(seen_we), 1);
          rd(a, d);
          chk("R5 ram readback", int'(d), int'(v));
        end else begin
          chk("R6 ram_we oob bank", int'(seen_we), 0);
          rd(a, d);
          chk("R6 oob read zero", int'(d), 0);
        end
      end
    end

    // R10: rollover chain
    set_clk(0, 8'd58); set_clk(1, 8'd59); set_clk(2, 8'd23);
    set_clk(3, 8'hFF); set_clk(4, 8'h01);
    tick();
    rd_clk(0, d); chk("R10 sec 59", int'(d), 59);
    tick();
    rd_clk(0, d); chk("R10 sec wrap", int'(d), 0);
    rd_clk(1, d); chk("R10 min wrap", int'(d), 0);
    rd_clk(2, d); chk("R10 hr wrap", int'(d), 0);
    rd_clk(3, d); chk("R10 day low wrap", int'(d), 0);
    rd_clk(4, d); chk("R10 day high carry", int'(d), 'h80);
    set_clk(0, 8'd59); set_clk(1, 8'd10);
    tick();
    rd_clk(1, d); chk("R10 min step", int'(d), 11);

    // R11: halt
    set_clk(4, 8'hFF);
    rd_clk(4, d); chk("R7 day high mask", int'(d), 'hC1);
    set_clk(0, 8'd20);
    tick(); tick();
    rd_clk(0, d); chk("R11 halted sec", int'(d), 20);
    set_clk(4, 8'h00);
    tick();
    rd_clk(0, d); chk("R11 running sec", int'(d), 21);

    // R9: latch
    set_clk(0, 8'd10);
    wr(16'h6000, 8'h01);
    tick();
    rd(16'hA000, d); chk("R9 latched read", int'(d), 10);
    wr(16'h7FFF, 8'h02);
    rd(16'hA000, d); chk("R9 released read", int'(d), 11);
    wr(16'h6000, 8'h03);
    tick();
    rd(16'hA000, d); chk("R9 relatched read", int'(d), 11);
    wr(16'h6000, 8'h00);
    rd(16'hA000, d); chk("R9 live after release", int'(d), 12);

    // R12: write wins over same-cycle tick
    wr(16'h4000, 8'h08);
    wr(16'hA000, 8'd30, 1'b1);
    rd(16'hA000, d); chk("R12 write wins", int'(d), 30);
    rd_clk(1, d); chk("R12 tick dropped", int'(d), 11);

    finish_run();
  end
endmodule